// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Mode Gating

This block is a two-way set-associative cache between a CPU-side request port and a memory port that moves one line per transaction. A CPU address is split into a tag, a set index and a byte offset. The index selects one set, and the tags of both ways in that set are compared at the same time. A hit is served from the cache. A miss picks a victim way, using one recency bit per set. If the victim was modified since it was loaded, it is written to memory before the new line is fetched.

A two-bit configuration register gates the cache's behaviour. The fill-off bit stops allocation, so read misses are served straight from memory. The write-through-off bit stops write-through traffic and stops external invalidations. Only three of the four encodings are legal. A write of the fourth encoding leaves the current mode in place and sets a sticky error flag.

A snoop input names a line address. When invalidation is enabled, a matching resident line becomes invalid. Dirty data is not written back on a snoop.

Top module: `cache2w_top`

## Requirements
- R1: The CPU address is split, from the top bit down, into a tag (ADDR_W-SET_W-2 bits), a set index (SET_W bits) and a 2-bit byte offset. The offset does not take part in lookup, so two addresses that differ only in the offset hit the same line.
- R2: A read hit returns the cached word with cpu_ready asserted on the second rising edge after the request is accepted, and the memory port is not used.
- R3: Each set holds two independent lines, and lines with two different tags in the same set can be resident at once.
- R4: On a miss, the victim is an invalid way if one exists (way 0 first). Otherwise it is the way used least recently in that set.
- R5: A dirty victim is written to memory, at its own tag and set, before the read of the missing line is issued.
- R6: A clean victim is overwritten without any memory write.
- R7: With cfg_wt_off=0, a write hit updates the line and issues one memory write, and the line stays clean.
- R8: With cfg_wt_off=1, a write hit issues no memory traffic and marks the line dirty. That data reaches memory only when the line is later evicted.
- R9: With cfg_fill_off=1, a read miss returns the memory word through a bypass read and allocates nothing, so a repeat read misses again. Read hits are still served from the cache.
- R10: After reset, cfg_fill_off=0, cfg_wt_off=0 and cfg_err=0. Writing the encoding fill_off=0, wt_off=1 leaves both mode bits unchanged and sets cfg_err, which stays set until reset.
- R11: A snoop clears the valid bit of a matching line when cfg_wt_off=0, does nothing when cfg_wt_off=1, and never causes a memory write.
- R12: A write miss with fills enabled allocates the line without a memory read and writes it through. With fills disabled, a write miss only forwards the word to memory.
- R13: cpu_ready is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, held with stable fields until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request complete (one-cycle pulse) |
| mem_req | output | 1 | Memory transaction request, held until mem_ack |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 22 | Line address {tag, set} |
| mem_wdata | output | 32 | Line write data |
| mem_rdata | input | 32 | Line read data, valid with mem_ack |
| mem_ack | input | 1 | Memory transaction done |
| snp_valid | input | 1 | Snoop invalidate strobe |
| snp_line | input | 22 | Snooped line address {tag, set} |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fill_off_in | input | 1 | Fill-off value to write |
| cfg_wt_off_in | input | 1 | Write-through-off value to write |
| cfg_fill_off | output | 1 | Current fill-off bit |
| cfg_wt_off | output | 1 | Current write-through/invalidate-off bit |
| cfg_err | output | 1 | Sticky illegal-mode flag |

## Verification
The hardest situation to reach is a dirty victim. In the normal mode every write is written through, so no line ever becomes dirty. The stimulus fills both ways of a set and then switches to the all-off mode, where a write hit leaves a line dirty. It then touches the other way so that the dirty line becomes least recently used, returns to the normal mode and forces a miss in that set. At that point it checks that the memory write comes before the memory read and that it carries the dirty word. A similar detour through the modes checks that a snoop drops dirty data without writing it back.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef struct packed {
    logic fill_en;
    logic wt_en;
    logic inv_en;
  } mode_en_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WB,
    S_FILL,
    S_MWR
  } cstate_t;

  function automatic mode_en_t decode_mode(input logic fill_off, input logic wt_off);
    mode_en_t m;
    m.fill_en = !fill_off;
    m.wt_en   = !wt_off;
    m.inv_en  = !wt_off;
    return m;
  endfunction

  function automatic logic mode_illegal(input logic fill_off, input logic wt_off);
    return !fill_off && wt_off;
  endfunction

  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/cache2w_mode.sv
module cache2w_mode
  import cache2w_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_fill_off,
  input  logic     wr_wt_off,
  output logic     fill_off,
  output logic     wt_off,
  output logic     err,
  output mode_en_t men
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_off <= 1'b0;
      wt_off   <= 1'b0;
      err      <= 1'b0;
    end else if (wr_en) begin
      if (mode_illegal(wr_fill_off, wr_wt_off)) begin
        err <= 1'b1;
      end else begin
        fill_off <= wr_fill_off;
        wt_off   <= wr_wt_off;
      end
    end
  end

  assign men = decode_mode(fill_off, wt_off);

endmodule

// File: rtl/cache2w_ways.sv
module cache2w_ways #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << SET_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       lk_set,
  input  logic [TAG_W-1:0]       lk_tag,
  output logic [1:0]             lk_hit,
  output logic [1:0]             lk_vld,
  output logic [1:0]             lk_dirty,
  output logic [1:0][TAG_W-1:0]  lk_tags,
  output logic [1:0][DATA_W-1:0] lk_data,
  output logic                   lk_lru,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_dirty,
  input  logic                   lru_en,
  input  logic                   lru_way,
  input  logic                   snp_en,
  input  logic [SET_W-1:0]       snp_set,
  input  logic [TAG_W-1:0]       snp_tag
);

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   dty_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic              sel_wr;
    logic              snp_hit;

    assign sel_wr  = wr_en && (wr_way == 1'(w));
    assign snp_hit = snp_en && vld_q[snp_set] && (tag_q[snp_set] == snp_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else begin
        if (sel_wr) begin
          vld_q[lk_set] <= 1'b1;
          dty_q[lk_set] <= wr_dirty;
        end
        if (snp_hit) vld_q[snp_set] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        tag_q[lk_set] <= lk_tag;
        dat_q[lk_set] <= wr_data;
      end
    end

    assign lk_vld[w]   = vld_q[lk_set];
    assign lk_dirty[w] = dty_q[lk_set];
    assign lk_tags[w]  = tag_q[lk_set];
    assign lk_data[w]  = dat_q[lk_set];
    assign lk_hit[w]   = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (lru_en) lru_q[lk_set] <= !lru_way;
  end

  assign lk_lru = lru_q[lk_set];

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int SET_W  = 6,
  parameter int DATA_W = 32,
  localparam int TAG_W  = ADDR_W - SET_W - OFS_W,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic                   cpu_ready,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [LINE_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ack,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  mode_en_t               men,
  output logic [SET_W-1:0]       lk_set,
  output logic [TAG_W-1:0]       lk_tag,
  input  logic [1:0]             lk_hit,
  input  logic [1:0]             lk_vld,
  input  logic [1:0]             lk_dirty,
  input  logic [1:0][TAG_W-1:0]  lk_tags,
  input  logic [1:0][DATA_W-1:0] lk_data,
  input  logic                   lk_lru,
  output logic                   wr_en,
  output logic                   wr_way,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   wr_dirty,
  output logic                   lru_en,
  output logic                   lru_way,
  output logic                   ev_look,
  output logic                   ev_hit,
  output logic                   ev_we,
  output logic                   ev_wb_ack
);

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  cstate_t           st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              vic_q;
  logic [TAG_W-1:0]  vtag_q;
  logic [DATA_W-1:0] vdata_q;
  logic              alloc_q;

  logic hit, hway, vic, vic_dirty;

  assign lk_set    = set_of(a_q);
  assign lk_tag    = tag_of(a_q);
  assign hit       = |lk_hit;
  assign hway      = lk_hit[1];
  assign vic       = pick_victim(lk_vld, lk_lru);
  assign vic_dirty = lk_vld[vic] && lk_dirty[vic];

  assign ev_look   = (st == S_LOOK);
  assign ev_hit    = hit;
  assign ev_we     = we_q;
  assign ev_wb_ack = (st == S_WB) && mem_ack;

  // Array write port and recency update
  always_comb begin
    wr_en    = 1'b0;
    wr_way   = vic_q;
    wr_data  = wd_q;
    wr_dirty = 1'b0;
    lru_en   = 1'b0;
    lru_way  = vic_q;
    case (st)
      S_LOOK: begin
        if (hit) begin
          lru_en  = 1'b1;
          lru_way = hway;
          if (we_q) begin
            wr_en    = 1'b1;
            wr_way   = hway;
            wr_dirty = !men.wt_en;
          end
        end else if (men.fill_en && !vic_dirty && we_q) begin
          wr_en    = 1'b1;
          wr_way   = vic;
          wr_dirty = !men.wt_en;
          lru_en   = 1'b1;
          lru_way  = vic;
        end
      end
      S_WB: begin
        if (mem_ack && we_q) begin
          wr_en    = 1'b1;
          wr_dirty = !men.wt_en;
          lru_en   = 1'b1;
        end
      end
      S_FILL: begin
        if (mem_ack && alloc_q) begin
          wr_en   = 1'b1;
          wr_data = mem_rdata;
          lru_en  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a_q       <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      vic_q     <= 1'b0;
      vtag_q    <= '0;
      vdata_q   <= '0;
      alloc_q   <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cpu_req) begin
            a_q  <= cpu_addr;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
            st   <= S_LOOK;
          end
        end
        S_LOOK: begin
          alloc_q <= men.fill_en;
          vic_q   <= vic;
          vtag_q  <= lk_tags[vic];
          vdata_q <= lk_data[vic];
          if (hit) begin
            if (!we_q) begin
              cpu_rdata <= lk_data[hway];
              cpu_ready <= 1'b1;
              st        <= S_IDLE;
            end else if (men.wt_en) begin
              st <= S_MWR;
            end else begin
              cpu_ready <= 1'b1;
              st        <= S_IDLE;
            end
          end else if (men.fill_en) begin
            if (vic_dirty)          st <= S_WB;
            else if (!we_q)         st <= S_FILL;
            else if (men.wt_en)     st <= S_MWR;
            else begin
              cpu_ready <= 1'b1;
              st        <= S_IDLE;
            end
          end else begin
            st <= we_q ? S_MWR : S_FILL;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            if (!we_q)          st <= S_FILL;
            else if (men.wt_en) st <= S_MWR;
            else begin
              cpu_ready <= 1'b1;
              st        <= S_IDLE;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            cpu_rdata <= mem_rdata;
            cpu_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_MWR: begin
          if (mem_ack) begin
            cpu_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_MWR);
  assign mem_we    = (st == S_WB) || (st == S_MWR);
  assign mem_addr  = (st == S_WB) ? {vtag_q, lk_set} : a_q[ADDR_W-1:OFS_W];
  assign mem_wdata = (st == S_WB) ? vdata_q : wd_q;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int SET_W  = 6,
  parameter int DATA_W = 32,
  localparam int TAG_W  = ADDR_W - SET_W - OFS_W,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LINE_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              cfg_we,
  input  logic              cfg_fill_off_in,
  input  logic              cfg_wt_off_in,
  output logic              cfg_fill_off,
  output logic              cfg_wt_off,
  output logic              cfg_err
);

  mode_en_t              men;
  logic [SET_W-1:0]      lk_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [1:0]            lk_hit, lk_vld, lk_dirty;
  logic [1:0][TAG_W-1:0] lk_tags;
  logic [1:0][DATA_W-1:0] lk_data;
  logic                  lk_lru;
  logic                  wr_en, wr_way, wr_dirty, lru_en, lru_way;
  logic [DATA_W-1:0]     wr_data;
  logic                  snp_en;
  logic                  ev_look, ev_hit, ev_we, ev_wb_ack;

  assign snp_en = snp_valid && men.inv_en;

  cache2w_mode i_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_we),
    .wr_fill_off (cfg_fill_off_in),
    .wr_wt_off   (cfg_wt_off_in),
    .fill_off    (cfg_fill_off),
    .wt_off      (cfg_wt_off),
    .err         (cfg_err),
    .men         (men)
  );

  cache2w_ways #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_ways (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .lk_hit   (lk_hit),
    .lk_vld   (lk_vld),
    .lk_dirty (lk_dirty),
    .lk_tags  (lk_tags),
    .lk_data  (lk_data),
    .lk_lru   (lk_lru),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_data  (wr_data),
    .wr_dirty (wr_dirty),
    .lru_en   (lru_en),
    .lru_way  (lru_way),
    .snp_en   (snp_en),
    .snp_set  (snp_line[SET_W-1:0]),
    .snp_tag  (snp_line[LINE_W-1 -: TAG_W])
  );

  cache2w_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SET_W(SET_W), .DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .men       (men),
    .lk_set    (lk_set),
    .lk_tag    (lk_tag),
    .lk_hit    (lk_hit),
    .lk_vld    (lk_vld),
    .lk_dirty  (lk_dirty),
    .lk_tags   (lk_tags),
    .lk_data   (lk_data),
    .lk_lru    (lk_lru),
    .wr_en     (wr_en),
    .wr_way    (wr_way),
    .wr_data   (wr_data),
    .wr_dirty  (wr_dirty),
    .lru_en    (lru_en),
    .lru_way   (lru_way),
    .ev_look   (ev_look),
    .ev_hit    (ev_hit),
    .ev_we     (ev_we),
    .ev_wb_ack (ev_wb_ack)
  );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_ready,
  input logic mem_req,
  input logic mem_we,
  input logic mem_ack,
  input logic cfg_we,
  input logic cfg_fill_off_in,
  input logic cfg_wt_off_in,
  input logic cfg_fill_off,
  input logic cfg_wt_off,
  input logic cfg_err,
  input logic ev_look,
  input logic ev_hit,
  input logic ev_we,
  input logic ev_wb_ack
);

  p_ready_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_read_hit_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_look && ev_hit && !ev_we) |=> (cpu_ready && !mem_req));

  p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_ack && !ev_we) |=> (mem_req && !mem_we));

  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  p_wtoff_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_look && ev_hit && ev_we && cfg_wt_off) |=> (cpu_ready && !mem_req));

  p_nofill_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_look && !ev_hit && !ev_we && cfg_fill_off) |=> (mem_req && !mem_we));

  p_illegal_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_fill_off_in && cfg_wt_off_in)
      |=> ($stable(cfg_fill_off) && $stable(cfg_wt_off) && cfg_err));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind cache2w_top cache2w_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_ready       (cpu_ready),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_ack         (mem_ack),
  .cfg_we          (cfg_we),
  .cfg_fill_off_in (cfg_fill_off_in),
  .cfg_wt_off_in   (cfg_wt_off_in),
  .cfg_fill_off    (cfg_fill_off),
  .cfg_wt_off      (cfg_wt_off),
  .cfg_err         (cfg_err),
  .ev_look         (ev_look),
  .ev_hit          (ev_hit),
  .ev_we           (ev_we),
  .ev_wb_ack       (ev_wb_ack)
);

// File: tb/test_cache2w_top.sv
module test_cache2w_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        snp_valid = 1'b0;
  logic [21:0] snp_line = '0;
  logic        cfg_we = 1'b0, cfg_fill_off_in = 1'b0, cfg_wt_off_in = 1'b0;
  logic        cfg_fill_off, cfg_wt_off, cfg_err;

  int n_chk = 0;
  int n_err = 0;
  int n_rd = 0;
  int n_wr = 0;
  int wait_c = 0;
  int cyc_all = 0;
  logic [31:0] op_log = '0;
  logic [31:0] mem_img [256];

  always #5 clk = !clk;

  cache2w_top i_cache2w_top (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .snp_valid(snp_valid), .snp_line(snp_line),
    .cfg_we(cfg_we), .cfg_fill_off_in(cfg_fill_off_in),
    .cfg_wt_off_in(cfg_wt_off_in), .cfg_fill_off(cfg_fill_off),
    .cfg_wt_off(cfg_wt_off), .cfg_err(cfg_err)
  );

  // Memory model: image indexed by {tag[1:0], set}, ack after two waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_img[i] = 32'h5A00_0000 + i;
      mem_ack = 1'b0;
      wait_c  = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      wait_c++;
      if (wait_c == 2) begin
        wait_c  = 0;
        mem_ack = 1'b1;
        op_log  = {op_log[30:0], mem_we};
        if (mem_we) begin
          mem_img[mem_addr[7:0]] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = mem_img[mem_addr[7:0]];
          n_rd++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL R13 watchdog: actual %0d cycles expected fewer", cyc_all);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [23:0] mk(input int tag, input int set, input int ofs);
    return {16'(tag), 6'(set), 2'(ofs)};
  endfunction

  function automatic logic [21:0] ln(input int tag, input int set);
    return {16'(tag), 6'(set)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [23:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int nr, output int nw,
                        output int cyc, output logic first_we);
    int r0, w0;
    r0 = n_rd;
    w0 = n_wr;
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    cpu_req = 1'b0;
    rd = cpu_rdata;
    nr = n_rd - r0;
    nw = n_wr - w0;
    first_we = (nr + nw > 0) ? op_log[nr + nw - 1] : 1'b0;
    chk(cyc < 200, "R13", "request completes", 32'(cyc), 32'd200);
    @(negedge clk);
    chk(!cpu_ready, "R13", "ready is one cycle", 32'(cpu_ready), 32'd0);
  endtask

  task automatic do_cfg(input logic fo, input logic wo);
    cfg_fill_off_in = fo; cfg_wt_off_in = wo; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_snoop(input logic [21:0] l, output int reqs);
    reqs = 0;
    snp_line = l; snp_valid = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (mem_req) reqs++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] tag;
    logic [5:0]  set;
    logic [1:0]  ofs;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [1:0]  nrd;
    logic [1:0]  nwr;
    logic [3:0]  req;
  } vec_t;
  localparam int VW = $bits(vec_t);
  localparam int NV = 14;

  // Mode fill-on / write-through-on; all in set 1 except the last two (set 2)
  localparam logic [VW-1:0] VT [NV] = '{
    {1'b0, 16'd0, 6'd1, 2'd0, 32'h0,         32'h5A000001, 2'd1, 2'd0, 4'd3},  // R3 fill way0
    {1'b0, 16'd0, 6'd1, 2'd3, 32'h0,         32'h5A000001, 2'd0, 2'd0, 4'd1},  // R1 offset ignored
    {1'b0, 16'd1, 6'd1, 2'd0, 32'h0,         32'h5A000041, 2'd1, 2'd0, 4'd3},  // R3 fill way1
    {1'b0, 16'd0, 6'd1, 2'd0, 32'h0,         32'h5A000001, 2'd0, 2'd0, 4'd3},  // R3 both resident
    {1'b0, 16'd2, 6'd1, 2'd0, 32'h0,         32'h5A000081, 2'd1, 2'd0, 4'd6},  // R6 clean evict
    {1'b0, 16'd1, 6'd1, 2'd0, 32'h0,         32'h5A000041, 2'd1, 2'd0, 4'd4},  // R4 evicts tag0
    {1'b0, 16'd2, 6'd1, 2'd0, 32'h0,         32'h5A000081, 2'd0, 2'd0, 4'd4},  // R4 tag2 kept
    {1'b1, 16'd2, 6'd1, 2'd0, 32'h11112222,  32'h0,        2'd0, 2'd1, 4'd7},  // R7 write hit
    {1'b0, 16'd2, 6'd1, 2'd0, 32'h0,         32'h11112222, 2'd0, 2'd0, 4'd2},  // R2 hit data
    {1'b0, 16'd0, 6'd1, 2'd0, 32'h0,         32'h5A000001, 2'd1, 2'd0, 4'd4},  // R4 evicts tag1
    {1'b0, 16'd3, 6'd1, 2'd0, 32'h0,         32'h5A0000C1, 2'd1, 2'd0, 4'd7},  // R7 line stayed clean
    {1'b0, 16'd2, 6'd1, 2'd0, 32'h0,         32'h11112222, 2'd1, 2'd0, 4'd7},  // R7 memory updated
    {1'b1, 16'd1, 6'd2, 2'd0, 32'h33334444,  32'h0,        2'd0, 2'd1, 4'd12}, // R12 allocate no read
    {1'b0, 16'd1, 6'd2, 2'd0, 32'h0,         32'h33334444, 2'd0, 2'd0, 4'd12}  // R12 allocated
  };

  initial begin
    logic [31:0] rd;
    int nr, nw, cyc, sr;
    logic fw;
    vec_t v;

    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0, "R13", "reset ready", 32'(cpu_ready), 32'd0);
    chk(mem_req == 1'b0, "R2", "reset mem_req", 32'(mem_req), 32'd0);
    chk({cfg_fill_off, cfg_wt_off, cfg_err} == 3'b000, "R10", "reset mode",
        32'({cfg_fill_off, cfg_wt_off, cfg_err}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VT[i]);
      do_req(v.we, {v.tag, v.set, v.ofs}, v.wd, rd, nr, nw, cyc, fw);
      if (!v.we)
        chk(rd == v.exp, $sformatf("R%0d", v.req), $sformatf("vec %0d data", i), rd, v.exp);
      chk(nr == int'(v.nrd), $sformatf("R%0d", v.req), $sformatf("vec %0d mem reads", i),
          32'(nr), 32'(v.nrd));
      chk(nw == int'(v.nwr), $sformatf("R%0d", v.req), $sformatf("vec %0d mem writes", i),
          32'(nw), 32'(v.nwr));
      if (!v.we && v.nrd == 0 && v.nwr == 0)
        chk(cyc == 2, "R2", $sformatf("vec %0d hit latency", i), 32'(cyc), 32'd2);
    end
    chk(mem_img[8'h81] == 32'h11112222, "R7", "write-through image", mem_img[8'h81], 32'h11112222);

    // R8 and R5: dirty line from the all-off mode, evicted later
    do_req(1'b0, mk(0, 3, 0), 0, rd, nr, nw, cyc, fw);
    do_req(1'b0, mk(1, 3, 0), 0, rd, nr, nw, cyc, fw);
    do_cfg(1'b1, 1'b1);
    do_req(1'b1, mk(0, 3, 0), 32'hDEAD0001, rd, nr, nw, cyc, fw);
    chk(nr + nw == 0, "R8", "write hit silent", 32'(nr + nw), 32'd0);
    chk(mem_img[3] == 32'h5A000003, "R8", "memory untouched", mem_img[3], 32'h5A000003);
    do_req(1'b0, mk(0, 3, 0), 0, rd, nr, nw, cyc, fw);
    chk(rd == 32'hDEAD0001, "R8", "dirty data read", rd, 32'hDEAD0001);
    do_req(1'b0, mk(1, 3, 0), 0, rd, nr, nw, cyc, fw);
    do_cfg(1'b0, 1'b0);
    do_req(1'b0, mk(2, 3, 0), 0, rd, nr, nw, cyc, fw);
    chk(nw == 1 && nr == 1, "R5", "write-back plus fill", 32'(nw * 16 + nr), 32'h11);
    chk(fw == 1'b1, "R5", "write-back first", 32'(fw), 32'd1);
    chk(mem_img[3] == 32'hDEAD0001, "R5", "victim data", mem_img[3], 32'hDEAD0001);
    chk(rd == 32'h5A000083, "R5", "refill data", rd, 32'h5A000083);

    // R9 and R12: fills disabled
    do_req(1'b0, mk(0, 4, 0), 0, rd, nr, nw, cyc, fw);
    do_cfg(1'b1, 1'b0);
    do_req(1'b0, mk(0, 4, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 0 && rd == 32'h5A000004, "R9", "hit served from cache", rd, 32'h5A000004);
    do_req(1'b0, mk(1, 4, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 1 && rd == 32'h5A000044, "R9", "bypass read", rd, 32'h5A000044);
    do_req(1'b0, mk(1, 4, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 1, "R9", "no allocation", 32'(nr), 32'd1);
    do_req(1'b1, mk(2, 4, 0), 32'h00000077, rd, nr, nw, cyc, fw);
    chk(nr == 0 && nw == 1, "R12", "write miss forwarded", 32'(nw * 16 + nr), 32'h10);
    chk(mem_img[8'h84] == 32'h77, "R12", "forwarded data", mem_img[8'h84], 32'h77);
    do_req(1'b1, mk(0, 4, 0), 32'h0000AAAA, rd, nr, nw, cyc, fw);
    chk(nw == 1 && mem_img[4] == 32'hAAAA, "R7", "write-through in fill-off", mem_img[4], 32'hAAAA);

    // R10: illegal encoding
    do_cfg(1'b0, 1'b1);
    @(negedge clk);
    chk({cfg_fill_off, cfg_wt_off, cfg_err} == 3'b101, "R10", "illegal ignored",
        32'({cfg_fill_off, cfg_wt_off, cfg_err}), 32'h5);
    do_cfg(1'b0, 1'b0);
    @(negedge clk);
    chk({cfg_fill_off, cfg_wt_off, cfg_err} == 3'b001, "R10", "err sticky",
        32'({cfg_fill_off, cfg_wt_off, cfg_err}), 32'h1);

    // R11: snoop gating and no write-back of dirty data
    do_req(1'b0, mk(0, 5, 0), 0, rd, nr, nw, cyc, fw);
    do_snoop(ln(0, 5), sr);
    chk(sr == 0, "R11", "snoop no traffic", 32'(sr), 32'd0);
    do_req(1'b0, mk(0, 5, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 1, "R11", "snooped line gone", 32'(nr), 32'd1);
    do_cfg(1'b1, 1'b1);
    do_snoop(ln(0, 5), sr);
    do_cfg(1'b0, 1'b0);
    do_req(1'b0, mk(0, 5, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 0, "R11", "snoop ignored when off", 32'(nr), 32'd0);
    do_req(1'b0, mk(0, 6, 0), 0, rd, nr, nw, cyc, fw);
    do_cfg(1'b1, 1'b1);
    do_req(1'b1, mk(0, 6, 0), 32'hBEEF0006, rd, nr, nw, cyc, fw);
    do_cfg(1'b1, 1'b0);
    nw = n_wr;
    do_snoop(ln(0, 6), sr);
    chk(n_wr == nw && sr == 0, "R11", "dirty not written back", 32'(n_wr - nw), 32'd0);
    do_req(1'b0, mk(0, 6, 0), 0, rd, nr, nw, cyc, fw);
    chk(nr == 1 && rd == 32'h5A000006, "R11", "dirty data dropped", rd, 32'h5A000006);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule